// File: doc/BRIEF.md
# Bridge Control Register File

This block is the word-addressed control and status register bank of a host bridge. A processor-side bus presents a byte address, a write enable and 32 bits of write data every cycle. The block answers with registered read data one cycle later. The bank holds power-on and general configuration, I/O and memory timing, address-map control, GPIO data and direction, interrupt steering and polarity, four mailbox words and several cache and timing words. Apart from the special words below, every mapped word is plain read/write storage; nothing outside the bank uses these values.

Three words behave differently. The interrupt-enable word cannot be written directly. A write to its set alias ORs the written value into it, and a write to its clear alias removes the written bits. Both aliases also keep the last value written to them. The general-config word watches its soft-reset bit, and a write that raises that bit from 0 to 1 produces a one-cycle reset request for the rest of the system.

Top module: `bridge_regs`

## Requirements
- R1: After reset the bank holds these values: offset 0x00 = 0x00000C40, 0x04 = 0x00001384, 0x08 = 0x2BFF8010, 0x0C = 0x255E0091, 0x10 = 0x00006140, 0x1C = 0x000001FF, 0x20 = 0x000001FF, 0x68 = 0x00000008, 0x6C = 0x10000000. Every other mapped word, the enable word included, is zero.
- R2: A word is addressed by byte address BASE_ADDR + offset, and its word index is offset >> 2. Address bits [1:0] are ignored. The window spans offsets 0x00 to 0x6F (28 words).
- R3: Plain words (every mapped offset other than 0x30, 0x34, 0x38 and 0x3C) store the written value. bus_rdata shows the word addressed in one cycle on the clock edge that ends that cycle, so it holds the value from before any write in that same cycle.
- R4: A write to the set alias at offset 0x30 stores the value in that alias and ORs it into the enable word at offset 0x38.
- R5: A write to the clear alias at offset 0x34 stores the value in that alias and clears every enable bit that is 1 in the written value.
- R6: Writes to the enable word (0x38) and to the status word (0x3C) are ignored. The status word always reads zero.
- R7: A write to general config (offset 0x04) that changes bit 2 from 0 to 1 stores the value and drives reset_req high for exactly the one cycle after that write.
- R8: A write to general config while its bit 2 is already 1, or one that leaves bit 2 at 0, stores the value and raises no reset_req.
- R9: Addresses outside the window (below BASE_ADDR, or at BASE_ADDR + 0x70 and above) drop writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
Every result of this block is due exactly one clock edge after the stimulus. Read data for an address appears after the edge that closes the cycle in which the address was driven. A reset request appears after the edge that takes the general-config write. The enable word changes on the edge of the alias write, and it can be seen one access later through a read. The bench drives every access on a falling edge and samples bus_rdata and reset_req on the next falling edge. It also checks that reset_req stays low after every read, so a request arriving one cycle late or lasting two cycles is caught.

// File: rtl/bridge_regs_pkg.sv
package bridge_regs_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned NUM_WORDS = 28;
    localparam int unsigned IDX_W     = $clog2(NUM_WORDS);
    localparam int unsigned WIN_BYTES = NUM_WORDS * 4;

    // Word indices whose behaviour other logic depends on
    localparam logic [IDX_W-1:0] W_GENCFG  = IDX_W'(1);
    localparam logic [IDX_W-1:0] W_EN_SET  = IDX_W'(12);
    localparam logic [IDX_W-1:0] W_EN_CLR  = IDX_W'(13);
    localparam logic [IDX_W-1:0] W_EN      = IDX_W'(14);
    localparam logic [IDX_W-1:0] W_STATUS  = IDX_W'(15);
    localparam int unsigned      SRST_BIT  = 2;

    typedef enum logic [1:0] {
        K_PLAIN,
        K_ALIAS_SET,
        K_ALIAS_CLR,
        K_READ_ONLY
    } word_kind_e;

    typedef struct packed {
        logic              wr;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic word_kind_e kind_of(input logic [IDX_W-1:0] idx);
        if (idx == W_EN_SET)                    return K_ALIAS_SET;
        if (idx == W_EN_CLR)                    return K_ALIAS_CLR;
        if (idx == W_EN || idx == W_STATUS)     return K_READ_ONLY;
        return K_PLAIN;
    endfunction

    function automatic logic [DATA_W-1:0] reset_value(input int unsigned idx);
        case (idx)
            0:       return 32'h0000_0C40;
            1:       return 32'h0000_1384;
            2:       return 32'h2BFF_8010;
            3:       return 32'h255E_0091;
            4:       return 32'h0000_6140;
            7:       return 32'h0000_01FF;
            8:       return 32'h0000_01FF;
            26:      return 32'h0000_0008;
            27:      return 32'h1000_0000;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/bridge_regs_decode.sv
module bridge_regs_decode
    import bridge_regs_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h100
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] WIN_LIMIT = ADDR_W'(WIN_BYTES);

    logic [ADDR_W-1:0] offset;
    logic              unused_byte_lanes;

    always_comb begin
        offset = addr - BASE_ADDR;
        hit    = (addr >= BASE_ADDR) && (offset < WIN_LIMIT);
        idx    = offset[IDX_W+1:2];
    end

    assign unused_byte_lanes = ^offset[1:0];

    always_comb begin
        a_r2_idx_in_range: assert (!hit || (idx < IDX_W'(NUM_WORDS)));
    end
endmodule

// File: rtl/bridge_regs_irqen.sv
module bridge_regs_irqen
    import bridge_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           req,
    output logic [DATA_W-1:0] en
);
    logic do_set, do_clr;

    always_comb begin
        do_set = req.wr && (kind_of(req.idx) == K_ALIAS_SET);
        do_clr = req.wr && (kind_of(req.idx) == K_ALIAS_CLR);
    end

    always_ff @(posedge clk) begin
        if (rst)         en <= '0;
        else if (do_set) en <= en | req.data;
        else if (do_clr) en <= en & ~req.data;
    end

    a_r4_set_merges: assert property (@(posedge clk) disable iff (rst)
        do_set |=> (((en & $past(req.data)) == $past(req.data)) &&
                    (($past(en) & ~en) == '0)));

    a_r5_clr_removes: assert property (@(posedge clk) disable iff (rst)
        do_clr |=> (((en & $past(req.data)) == '0) &&
                    ((en & ~$past(en)) == '0)));

    a_r6_en_hold: assert property (@(posedge clk) disable iff (rst)
        !(do_set || do_clr) |=> $stable(en));
endmodule

// File: rtl/bridge_regs_softrst.sv
module bridge_regs_softrst
    import bridge_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           req,
    input  logic [DATA_W-1:0] gencfg_q,
    output logic              reset_req
);
    logic gen_wr, rising;

    always_comb begin
        gen_wr = req.wr && (req.idx == W_GENCFG);
        rising = gen_wr && !gencfg_q[SRST_BIT] && req.data[SRST_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) reset_req <= 1'b0;
        else     reset_req <= rising;
    end

    a_r7_pulse_on_rise: assert property (@(posedge clk) disable iff (rst)
        (gen_wr && !gencfg_q[SRST_BIT] && req.data[SRST_BIT]) |=> reset_req);

    a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req);

    a_r8_no_pulse_when_set: assert property (@(posedge clk) disable iff (rst)
        (gen_wr && gencfg_q[SRST_BIT]) |=> !reset_req);

    a_r8_no_pulse_idle: assert property (@(posedge clk) disable iff (rst)
        !gen_wr |=> !reset_req);
endmodule

// File: rtl/bridge_regs.sv
module bridge_regs
    import bridge_regs_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              reset_req
);
    logic              hit;
    logic [IDX_W-1:0]  idx;
    wr_req_t           req;
    logic [DATA_W-1:0] en;
    logic [DATA_W-1:0] store [NUM_WORDS];

    bridge_regs_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr (bus_addr),
        .hit  (hit),
        .idx  (idx)
    );

    always_comb begin
        req.wr   = bus_we && hit;
        req.idx  = idx;
        req.data = bus_wdata;
    end

    // Plain words and both aliases keep the written value; read-only slots never change
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WORDS; i++) store[i] <= reset_value(i);
        end else if (req.wr && (kind_of(req.idx) != K_READ_ONLY)) begin
            store[req.idx] <= req.data;
        end
    end

    bridge_regs_irqen u_irqen (
        .clk (clk),
        .rst (rst),
        .req (req),
        .en  (en)
    );

    bridge_regs_softrst u_softrst (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .gencfg_q  (store[W_GENCFG]),
        .reset_req (reset_req)
    );

    always_ff @(posedge clk) begin
        if (rst)               bus_rdata <= '0;
        else if (!hit)         bus_rdata <= '0;
        else if (idx == W_EN)  bus_rdata <= en;
        else                   bus_rdata <= store[idx];
    end

    a_r9_outside_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !hit |=> (bus_rdata == '0));

    a_r6_status_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (hit && idx == W_STATUS) |=> (bus_rdata == '0));

    a_r3_plain_write_lands: assert property (@(posedge clk) disable iff (rst)
        (req.wr && kind_of(req.idx) == K_PLAIN) |=>
            (store[$past(req.idx)] == $past(req.data)));
endmodule

// File: tb/bridge_regs_test.sv
module bridge_regs_test;
    localparam int unsigned AW   = 12;
    localparam logic [AW-1:0] BASE = 12'h100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m [28];
    logic [31:0] m_en;

    always #2 clk = ~clk;

    bridge_regs #(.ADDR_W(AW), .BASE_ADDR(BASE)) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .reset_req (reset_req)
    );

    function automatic logic [31:0] init_val(int i);
        case (i)
            0: return 32'hC40;       1: return 32'h1384;
            2: return 32'h2BFF8010;  3: return 32'h255E0091;
            4: return 32'h6140;      7: return 32'h1FF;
            8: return 32'h1FF;       26: return 32'h8;
            27: return 32'h10000000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit in_win(logic [AW-1:0] a);
        return (a >= BASE) && (a < BASE + 12'h70);
    endfunction

    function automatic logic [31:0] exp_read(logic [AW-1:0] a);
        int i;
        if (!in_win(a)) return 32'h0;
        i = int'((a - BASE) >> 2);
        if (i == 14) return m_en;
        if (i == 15) return 32'h0;
        return m[i];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(logic [AW-1:0] a, logic [31:0] d, string tag);
        bit pulse = 0;
        int i;
        if (in_win(a)) begin
            i = int'((a - BASE) >> 2);
            if (i == 1 && !m[1][2] && d[2]) pulse = 1;
            if (i == 12) begin m[12] = d; m_en |= d; end
            else if (i == 13) begin m[13] = d; m_en &= ~d; end
            else if (i != 14 && i != 15) m[i] = d;
        end
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        check(tag, {31'b0, reset_req}, {31'b0, pulse});
    endtask

    task automatic do_read(logic [AW-1:0] a, string tag);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        check(tag, bus_rdata, exp_read(a));
        check("R7 pulse width", {31'b0, reset_req}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 28; i++) m[i] = init_val(i);
        m_en = '0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset image
        for (int i = 0; i < 28; i++) do_read(BASE + 12'(i * 4), "R1 reset value");
        // R9 outside window
        do_write(BASE - 12'h4, 32'hDEADBEEF, "R9 write below");
        do_write(BASE + 12'h70, 32'hDEADBEEF, "R9 write above");
        do_read(BASE - 12'h4, "R9 read below");
        do_read(BASE + 12'h70, "R9 read above");
        do_read(BASE, "R9 word0 untouched");
        // R2 low address bits ignored
        do_write(BASE + 12'h4B, 32'h1234_5678, "R2 write lanes");
        do_read(BASE + 12'h48, "R2 aligned readback");
        do_read(BASE + 12'h49, "R2 unaligned readback");
        // R3 same-cycle write then read: old value first
        bus_addr = BASE + 12'h40; bus_wdata = 32'hCAFE_F00D; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        check("R3 read during write shows old", bus_rdata, m[16]);
        m[16] = 32'hCAFE_F00D;
        do_read(BASE + 12'h40, "R3 readback");
        // R4 / R5
        do_write(BASE + 12'h30, 32'h0000_00F0, "R4 set");
        do_read(BASE + 12'h38, "R4 enable after set");
        do_write(BASE + 12'h30, 32'h0000_0F00, "R4 set again");
        do_read(BASE + 12'h38, "R4 enable accumulates");
        do_read(BASE + 12'h30, "R4 alias stores");
        do_write(BASE + 12'h34, 32'h0000_0330, "R5 clear");
        do_read(BASE + 12'h38, "R5 enable after clear");
        do_read(BASE + 12'h34, "R5 alias stores");
        // R6 read-only words
        do_write(BASE + 12'h38, 32'hFFFF_FFFF, "R6 write enable");
        do_read(BASE + 12'h38, "R6 enable unchanged");
        do_write(BASE + 12'h3C, 32'hFFFF_FFFF, "R6 write status");
        do_read(BASE + 12'h3C, "R6 status zero");
        // R7 / R8 soft reset (reset value has bit 2 set)
        do_write(BASE + 12'h4, 32'h0000_1384, "R8 bit already set");
        do_write(BASE + 12'h4, 32'h0000_0000, "R8 clear bit");
        do_write(BASE + 12'h4, 32'h0000_0001, "R8 bit stays low");
        do_write(BASE + 12'h4, 32'h0000_0004, "R7 rising pulse");
        do_write(BASE + 12'h4, 32'h0000_0004, "R8 no second pulse");
        do_read(BASE + 12'h4, "R7 value stored");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int sel;
            logic [AW-1:0] a;
            sel = int'($urandom_range(0, 33));
            if (sel < 28)       a = BASE + 12'(sel * 4) + 12'($urandom_range(0, 3));
            else if (sel == 28) a = BASE - 12'h4;
            else if (sel == 29) a = BASE + 12'h74;
            else if (sel < 32)  a = BASE + 12'h4;
            else                a = BASE + 12'h30 + 12'($urandom_range(0, 1) * 4);
            if ($urandom_range(0, 1) == 1) do_write(a, $urandom(), "R3 random write");
            else                           do_read(a, "R3 random read");
        end
        for (int i = 0; i < 28; i++) do_read(BASE + 12'(i * 4), "R3 final sweep");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule